// File: doc/BRIEF.md
# Mixed-Mode Jump and Restart Unit

This block is the control-flow unit of a processor core that runs in two addressing modes. In the wide mode (mode bit = 1) every address is a flat 24-bit value. In the compatibility mode (mode bit = 0) the core works with 16-bit offsets, and the upper address byte comes from a page-base input. The unit executes two instruction families: register-indirect jumps and restarts. Each may carry a suffix prefix that overrides the mode. From the current mode, the suffix and the decoded operands, the unit computes the next program counter and the next mode bit.

A restart saves its return address on a stack before it branches. The unit keeps two stack pointers: a 16-bit short pointer, used inside the page-base page, and a 24-bit long pointer. It writes the return address one byte per clock through a byte-wide memory write port. A restart in compatibility mode that carries the short-short suffix also leaves a marker byte on the long stack.

The decoder presents the operation, the suffix code, the register value and the restart vector, together with a one-cycle start strobe. A one-cycle done strobe marks completion. If the mode and suffix pair is not a supported one, the done strobe comes with an illegal flag and no architectural state changes.

Top module: `mmode_flow_unit`

## Requirements
- R1: After reset the program counter, mode bit, short pointer and long pointer take their reset parameter values. done_o, illegal_o, busy_o and wr_en_o are all 0.
- R2: A jump (op_i = 0) in wide mode with suffix code 0 (none) or 1 (long-long) loads all 24 bits of reg_i into the PC and keeps the mode bit at 1. It makes no memory write.
- R3: A jump with suffix code 2 (short-long) in wide mode loads reg_i[15:0] into PC[15:0] and keeps PC[23:16]. It clears the mode bit, so fetch_addr_o becomes {mbase_i, PC[15:0]}.
- R4: A restart (op_i = 1) in wide mode with suffix code 0 writes PC[23:16], PC[15:8] and PC[7:0], in that order, at long pointer minus 1, minus 2 and minus 3. The long pointer wraps modulo 2^24. The PC then becomes {16'h0000, vec_i}.
- R5: A restart in compatibility mode with suffix code 0 writes PC[15:8] and then PC[7:0] at {mbase_i, short pointer minus 1} and {mbase_i, short pointer minus 2}. The short pointer wraps modulo 2^16. The unit then sets PC[15:0] to {8'h00, vec_i}. PC[23:16] and the long pointer do not change.
- R6: A restart in compatibility mode with suffix code 3 (short-short) does everything R5 describes. It then writes byte 8'h02 at long pointer minus 1 and leaves the long pointer decremented by one.
- R7: The unit issues at most one write per cycle, and the first write comes in the cycle after start. done_o pulses for one cycle: in the cycle after the last write, or in the cycle after start for a jump. The PC update becomes visible together with done_o.
- R8: These pairs are illegal: a jump in compatibility mode, a restart in wide mode with a nonzero suffix, and a restart in compatibility mode with suffix code 1 or 2. Each raises illegal_o together with done_o in the cycle after start. It makes no write and leaves the PC, the mode bit and both pointers unchanged.
- R9: start_i is ignored while busy_o is 1. It starts no new operation and causes no extra write.
- R10: The mode bit never rises except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| op_i | input | 1 | 0 = register-indirect jump, 1 = restart |
| sfx_i | input | 2 | Suffix code: 0 none, 1 long-long, 2 short-long, 3 short-short |
| reg_i | input | 24 | Register-pair value for jumps |
| vec_i | input | 8 | Restart vector |
| mbase_i | input | 8 | Page base for compatibility-mode addresses |
| pc_o | output | 24 | Program counter register |
| fetch_addr_o | output | 24 | Effective fetch address in the current mode |
| adl_o | output | 1 | Mode bit, 1 = wide |
| sps_o | output | 16 | Short stack pointer |
| spl_o | output | 24 | Long stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Unsupported mode and suffix pair, valid with done_o |
| wr_en_o | output | 1 | Memory byte write enable |
| wr_addr_o | output | 24 | Memory byte write address |
| wr_data_o | output | 8 | Memory byte write data |

## Verification
Two things happen at the same clock edge: the last stack write of a restart and the PC update. The PC must load the vector only after the final return byte has been written from the old PC. The bench records every write byte by byte and compares the data with the PC value held before the restart. It samples the new PC and done_o one cycle after the last write. A second pairing comes from a start strobe raised while a push is in progress. The bench holds start_i high into the push sequence with a different vector, then confirms the write count, the written bytes and the final PC all belong to the first request.

// File: rtl/mmode_pkg.sv
package mmode_pkg;
    localparam int AW  = 24;          // wide address width
    localparam int OW  = 16;          // compatibility offset width
    localparam int BW  = 8;           // byte width
    localparam int PW  = AW - OW;     // page byte width
    localparam int STW = 2;           // push step counter width

    typedef enum logic [1:0] {
        SFX_NONE = 2'd0,
        SFX_LL   = 2'd1,
        SFX_SL   = 2'd2,
        SFX_SS   = 2'd3
    } sfx_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_JP_FULL,
        K_JP_SHORT,
        K_RST_FULL,
        K_RST_SHORT,
        K_RST_MARK
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FIN
    } state_e;
endpackage

// File: rtl/mmode_decode.sv
module mmode_decode
    import mmode_pkg::*;
(
    input  logic       op_i,
    input  logic [1:0] sfx_i,
    input  logic       adl_i,
    output kind_e      kind_o,
    output logic       illegal_o
);
    sfx_e sfx;
    assign sfx = sfx_e'(sfx_i);

    always_comb begin
        kind_o    = K_NONE;
        illegal_o = 1'b0;
        if (adl_i) begin
            if (!op_i) begin
                case (sfx)
                    SFX_NONE, SFX_LL: kind_o = K_JP_FULL;
                    SFX_SL:           kind_o = K_JP_SHORT;
                    default:          illegal_o = 1'b1;
                endcase
            end else if (sfx == SFX_NONE) begin
                kind_o = K_RST_FULL;
            end else begin
                illegal_o = 1'b1;
            end
        end else begin
            if (op_i && sfx == SFX_NONE)    kind_o = K_RST_SHORT;
            else if (op_i && sfx == SFX_SS) kind_o = K_RST_MARK;
            else                            illegal_o = 1'b1;
        end
    end
endmodule

// File: rtl/mmode_push_seq.sv
module mmode_push_seq
    import mmode_pkg::*;
(
    input  kind_e          kind_i,
    input  logic [STW-1:0] step_i,
    input  logic [AW-1:0]  pc_i,
    input  logic [OW-1:0]  sps_i,
    input  logic [AW-1:0]  spl_i,
    input  logic [PW-1:0]  mbase_i,
    output logic           long_o,
    output logic [AW-1:0]  addr_o,
    output logic [BW-1:0]  data_o,
    output logic           last_o
);
    localparam logic [BW-1:0] MARK_BYTE = BW'(2);

    logic [OW-1:0] sps_dec;
    logic [AW-1:0] spl_dec;

    assign sps_dec = sps_i - OW'(1);
    assign spl_dec = spl_i - AW'(1);

    always_comb begin
        long_o = 1'b0;
        data_o = '0;
        last_o = 1'b0;
        case (kind_i)
            K_RST_FULL: begin
                long_o = 1'b1;
                case (step_i)
                    STW'(0): data_o = pc_i[AW-1:OW];
                    STW'(1): data_o = pc_i[OW-1:BW];
                    default: data_o = pc_i[BW-1:0];
                endcase
                last_o = (step_i == STW'(2));
            end
            K_RST_SHORT, K_RST_MARK: begin
                case (step_i)
                    STW'(0): data_o = pc_i[OW-1:BW];
                    STW'(1): data_o = pc_i[BW-1:0];
                    default: begin
                        data_o = MARK_BYTE;
                        long_o = 1'b1;
                    end
                endcase
                last_o = (kind_i == K_RST_SHORT) ? (step_i == STW'(1))
                                                 : (step_i == STW'(2));
            end
            default: ;
        endcase
        addr_o = long_o ? spl_dec : {mbase_i, sps_dec};
    end
endmodule

// File: rtl/mmode_flow_unit.sv
module mmode_flow_unit
    import mmode_pkg::*;
#(
    parameter logic [23:0] RESET_PC  = 24'h000000,
    parameter logic        RESET_ADL = 1'b1,
    parameter logic [15:0] RESET_SPS = 16'h0000,
    parameter logic [23:0] RESET_SPL = 24'h000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_i,
    input  logic [1:0]  sfx_i,
    input  logic [23:0] reg_i,
    input  logic [7:0]  vec_i,
    input  logic [7:0]  mbase_i,
    output logic [23:0] pc_o,
    output logic [23:0] fetch_addr_o,
    output logic        adl_o,
    output logic [15:0] sps_o,
    output logic [23:0] spl_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        illegal_o,
    output logic        wr_en_o,
    output logic [23:0] wr_addr_o,
    output logic [7:0]  wr_data_o
);
    typedef struct packed {
        state_e         state;
        kind_e          kind;
        logic [STW-1:0] step;
        logic           ill;
        logic [BW-1:0]  vec;
        logic [AW-1:0]  pc;
        logic           adl;
        logic [OW-1:0]  sps;
        logic [AW-1:0]  spl;
    } regs_t;

    regs_t r_q, r_d;

    kind_e         dec_kind;
    logic          dec_ill;
    logic          push_long;
    logic [AW-1:0] push_addr;
    logic [BW-1:0] push_data;
    logic          push_last;

    mmode_decode u_dec (
        .op_i      (op_i),
        .sfx_i     (sfx_i),
        .adl_i     (r_q.adl),
        .kind_o    (dec_kind),
        .illegal_o (dec_ill)
    );

    mmode_push_seq u_push (
        .kind_i  (r_q.kind),
        .step_i  (r_q.step),
        .pc_i    (r_q.pc),
        .sps_i   (r_q.sps),
        .spl_i   (r_q.spl),
        .mbase_i (mbase_i),
        .long_o  (push_long),
        .addr_o  (push_addr),
        .data_o  (push_data),
        .last_o  (push_last)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.kind = dec_kind;
                    r_d.ill  = dec_ill;
                    r_d.vec  = vec_i;
                    r_d.step = '0;
                    if (dec_ill) begin
                        r_d.state = ST_FIN;
                    end else begin
                        case (dec_kind)
                            K_JP_FULL: begin
                                r_d.pc    = reg_i;
                                r_d.state = ST_FIN;
                            end
                            K_JP_SHORT: begin
                                r_d.pc[OW-1:0] = reg_i[OW-1:0];
                                r_d.adl        = 1'b0;
                                r_d.state      = ST_FIN;
                            end
                            default: r_d.state = ST_PUSH;
                        endcase
                    end
                end
            end
            ST_PUSH: begin
                if (push_long) r_d.spl = r_q.spl - AW'(1);
                else           r_d.sps = r_q.sps - OW'(1);
                r_d.step = r_q.step + STW'(1);
                if (push_last) begin
                    if (r_q.kind == K_RST_FULL) r_d.pc = {{(AW-BW){1'b0}}, r_q.vec};
                    else                        r_d.pc[OW-1:0] = {{(OW-BW){1'b0}}, r_q.vec};
                    r_d.state = ST_FIN;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.kind  <= K_NONE;
            r_q.step  <= '0;
            r_q.ill   <= 1'b0;
            r_q.vec   <= '0;
            r_q.pc    <= RESET_PC;
            r_q.adl   <= RESET_ADL;
            r_q.sps   <= RESET_SPS;
            r_q.spl   <= RESET_SPL;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o         = r_q.pc;
    assign adl_o        = r_q.adl;
    assign sps_o        = r_q.sps;
    assign spl_o        = r_q.spl;
    assign fetch_addr_o = r_q.adl ? r_q.pc : {mbase_i, r_q.pc[OW-1:0]};
    assign busy_o       = (r_q.state != ST_IDLE);
    assign done_o       = (r_q.state == ST_FIN);
    assign illegal_o    = done_o && r_q.ill;
    assign wr_en_o      = (r_q.state == ST_PUSH);
    assign wr_addr_o    = push_addr;
    assign wr_data_o    = push_data;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    write_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o);

    // R8
    ill_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (pc_o == $past(pc_o) && adl_o == $past(adl_o) &&
                       sps_o == $past(sps_o) && spl_o == $past(spl_o)));

    // R5
    short_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !push_long) |=> (sps_o == $past(sps_o) - 16'd1 && $stable(spl_o)));

    // R4
    long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && push_long) |=> (spl_o == $past(spl_o) - 24'd1 && $stable(sps_o)));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !push_last) |=> $stable(pc_o));

    // R10
    adl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(adl_o));
endmodule

// File: tb/mmode_flow_unit_tb.sv
module mmode_flow_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [1:0]  sfx_i = 2'd0;
    logic [23:0] reg_i = '0;
    logic [7:0]  vec_i = '0;
    logic [7:0]  mbase_i = 8'hA5;
    logic [23:0] pc_o, fetch_addr_o, spl_o, wr_addr_o;
    logic [15:0] sps_o;
    logic        adl_o, busy_o, done_o, illegal_o, wr_en_o;
    logic [7:0]  wr_data_o;

    int checks = 0;
    int errors = 0;
    int nw;
    int lat;
    logic [23:0] la [0:7];
    logic [7:0]  ld [0:7];
    logic        ill_seen;

    always #2.5 clk = ~clk;

    mmode_flow_unit #(
        .RESET_PC  (24'h123456),
        .RESET_ADL (1'b1),
        .RESET_SPS (16'h0001),
        .RESET_SPL (24'h000002)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sfx_i(sfx_i),
        .reg_i(reg_i), .vec_i(vec_i), .mbase_i(mbase_i), .pc_o(pc_o),
        .fetch_addr_o(fetch_addr_o), .adl_o(adl_o), .sps_o(sps_o), .spl_o(spl_o),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rec();
        if (wr_en_o && nw < 8) begin
            la[nw] = wr_addr_o;
            ld[nw] = wr_data_o;
        end
        if (wr_en_o) nw++;
    endtask

    task automatic run_op(input logic op, input logic [1:0] sfx, input logic [23:0] rr,
                          input logic [7:0] nn, input bit hold);
        nw = 0;
        @(negedge clk);
        op_i = op; sfx_i = sfx; reg_i = rr; vec_i = nn; start_i = 1'b1;
        @(negedge clk);
        lat = 1;
        if (hold) begin
            vec_i = 8'h30; op_i = 1'b1; sfx_i = 2'd0;
            rec();
            @(negedge clk);
            lat = 2;
        end
        start_i = 1'b0;
        while (!done_o && lat < 20) begin
            rec();
            @(negedge clk);
            lat++;
        end
        ill_seen = illegal_o;
        chk("R7 no write with done", {31'd0, wr_en_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 pc", pc_o, 24'h123456);
        chk("R1 adl", adl_o, 1);
        chk("R1 sps", sps_o, 16'h0001);
        chk("R1 spl", spl_o, 24'h000002);
        chk("R1 strobes", {busy_o, done_o, illegal_o, wr_en_o}, 0);
    endtask

    task automatic t_rst_wide();
        run_op(1'b1, 2'd0, 24'h0, 8'h38, 1'b0);
        chk("R7 latency rst wide", lat, 4);
        chk("R4 write count", nw, 3);
        chk("R4 w0 addr", la[0], 24'h000001);
        chk("R4 w0 data", ld[0], 8'h12);
        chk("R4 w1 addr", la[1], 24'h000000);
        chk("R4 w1 data", ld[1], 8'h34);
        chk("R4 w2 addr wrap", la[2], 24'hFFFFFF);
        chk("R4 w2 data", ld[2], 8'h56);
        chk("R4 pc", pc_o, 24'h000038);
        chk("R4 spl", spl_o, 24'hFFFFFF);
        chk("R4 sps untouched", sps_o, 16'h0001);
        chk("R4 adl", adl_o, 1);
    endtask

    task automatic t_jp_full(input logic [1:0] sfx, input logic [23:0] rr);
        run_op(1'b0, sfx, rr, 8'h00, 1'b0);
        chk("R7 latency jump", lat, 1);
        chk("R2 no writes", nw, 0);
        chk("R2 pc", pc_o, rr);
        chk("R2 adl", adl_o, 1);
        chk("R2 fetch", fetch_addr_o, rr);
    endtask

    task automatic t_illegal(input logic op, input logic [1:0] sfx);
        logic [23:0] pc0, spl0;
        logic [15:0] sps0;
        logic        adl0;
        pc0 = pc_o; spl0 = spl_o; sps0 = sps_o; adl0 = adl_o;
        run_op(op, sfx, 24'hDEAD01, 8'h28, 1'b0);
        chk("R8 illegal flag", ill_seen, 1);
        chk("R8 latency", lat, 1);
        chk("R8 no writes", nw, 0);
        chk("R8 pc kept", pc_o, pc0);
        chk("R8 adl kept", adl_o, adl0);
        chk("R8 sps kept", sps_o, sps0);
        chk("R8 spl kept", spl_o, spl0);
    endtask

    task automatic t_jp_short();
        run_op(1'b0, 2'd2, 24'hFF8899, 8'h00, 1'b0);
        chk("R3 illegal low", ill_seen, 0);
        chk("R3 no writes", nw, 0);
        chk("R3 pc", pc_o, 24'h108899);
        chk("R3 adl", adl_o, 0);
        chk("R3 fetch", fetch_addr_o, 24'hA58899);
    endtask

    task automatic t_rst_short();
        run_op(1'b1, 2'd0, 24'h0, 8'h10, 1'b0);
        chk("R7 latency rst short", lat, 3);
        chk("R5 write count", nw, 2);
        chk("R5 w0 addr", la[0], 24'hA50000);
        chk("R5 w0 data", ld[0], 8'h88);
        chk("R5 w1 addr wrap", la[1], 24'hA5FFFF);
        chk("R5 w1 data", ld[1], 8'h99);
        chk("R5 sps", sps_o, 16'hFFFF);
        chk("R5 spl untouched", spl_o, 24'hFFFFFF);
        chk("R5 pc", pc_o, 24'h100010);
        chk("R5 fetch", fetch_addr_o, 24'hA50010);
        chk("R10 adl stays 0", adl_o, 0);
    endtask

    task automatic t_rst_mark();
        run_op(1'b1, 2'd3, 24'h0, 8'h20, 1'b0);
        chk("R7 latency rst mark", lat, 4);
        chk("R6 write count", nw, 3);
        chk("R6 w0 addr", la[0], 24'hA5FFFE);
        chk("R6 w0 data", ld[0], 8'h00);
        chk("R6 w1 addr", la[1], 24'hA5FFFD);
        chk("R6 w1 data", ld[1], 8'h10);
        chk("R6 marker addr", la[2], 24'hFFFFFE);
        chk("R6 marker data", ld[2], 8'h02);
        chk("R6 sps", sps_o, 16'hFFFD);
        chk("R6 spl", spl_o, 24'hFFFFFE);
        chk("R6 pc", pc_o, 24'h100020);
    endtask

    task automatic t_busy_ignore();
        run_op(1'b1, 2'd0, 24'h0, 8'h08, 1'b1);
        chk("R9 write count", nw, 2);
        chk("R9 w1 data", ld[1], 8'h20);
        chk("R9 pc from first", pc_o, 24'h100008);
        chk("R9 sps", sps_o, 16'hFFFB);
        nw = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rec();
        end
        chk("R9 no extra writes", nw, 0);
        chk("R9 idle", busy_o, 0);
        chk("R10 adl after all", adl_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rst_wide();
        t_jp_full(2'd0, 24'hABCDEF);
        t_jp_full(2'd1, 24'h102030);
        t_illegal(1'b1, 2'd3);
        t_illegal(1'b1, 2'd1);
        t_jp_short();
        t_rst_short();
        t_rst_mark();
        t_illegal(1'b0, 2'd0);
        t_illegal(1'b1, 2'd2);
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule